// File: doc/BRIEF.md
# Asynchronous Timer Clock Selector and Prescaler

This block picks the count source for an 8-bit timer from three mode inputs and divides that source to produce a one-cycle timer tick enable. It also drives the enable for the low-frequency crystal oscillator and a mask of shared pins that remain free for general-purpose I/O.

The candidate sources are modelled as single-cycle enable pulses sampled in one design clock domain:

- the internal I/O clock,
- the crystal oscillator,
- an external clock on the oscillator input pin,
- an alternate count pin.

The divider is a 10-bit counter that advances on each edge of the selected source. A 3-bit select picks one of these settings:

- stop,
- pass-through,
- one of six power-of-two taps.

A clear strobe restarts the division from zero. Any change of the mode inputs also restarts it, so the first tick after a restart comes a known number of source edges later. Combinations the mode table leaves undefined stop all ticking and set a sticky error flag.

Top module: `tmr_clk_sel`

## Requirements
- R1: Pin mask bit 0 is the alternate count pin, bit 1 the middle shared pin, bit 2 the oscillator input pin. With async_en=0 and ext_en=0, for either value of alt_sel, the source is io_pulse, osc_en is 0 and pins_free is 3'b111.
- R2: With async_en=1, ext_en=0, alt_sel=0, the source is xtal_pulse, osc_en is 1 and pins_free is 3'b001.
- R3: With async_en=1, ext_en=1, alt_sel=0, the source is xin_pulse, osc_en is 0 and pins_free is 3'b011.
- R4: With async_en=1, ext_en=0, alt_sel=1, the source is alt_pulse, osc_en is 1 and pins_free is 3'b000.
- R5: With async_en=1, ext_en=1, alt_sel=1, the source is alt_pulse, osc_en is 0 and pins_free is 3'b110.
- R6: With async_en=0 and ext_en=1, no pulse produces a tick, osc_en is 0 and pins_free is 3'b000. cfg_err rises one cycle after such a combination is applied and stays 1 until rst_n.
- R7: div_sel=0 produces no ticks. div_sel=1 raises tick in the cycle after each selected source pulse.
- R8: div_sel values 2 to 7 divide by 8, 32, 64, 128, 256 and 1024. After a restart, tick rises in the cycle after the N-th selected pulse, and again after every further N pulses.
- R9: pre_clr restarts the count from zero. A source pulse in the same cycle as pre_clr is not counted and gives no tick.
- R10: A cycle in which {async_en, ext_en, alt_sel} differs from the previous cycle restarts the count exactly as pre_clr does.
- R11: While rst_n is low and after its release, tick and cfg_err are 0, and the count starts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_pulse | input | 1 | Edge pulse of the internal I/O clock |
| xtal_pulse | input | 1 | Edge pulse of the crystal oscillator |
| xin_pulse | input | 1 | Edge pulse of an external clock on the oscillator input pin |
| alt_pulse | input | 1 | Edge pulse from the alternate count pin |
| async_en | input | 1 | Asynchronous mode enable |
| ext_en | input | 1 | External clock enable |
| alt_sel | input | 1 | Alternate pin select |
| div_sel | input | 3 | Prescale select: 0 stop, 1 pass-through, 2..7 taps /8../1024 |
| pre_clr | input | 1 | Prescaler clear strobe |
| tick | output | 1 | One-cycle timer tick enable |
| osc_en | output | 1 | Crystal oscillator enable |
| pins_free | output | 3 | Shared pins available as GPIO |
| cfg_err | output | 1 | Sticky undefined-mode flag |

## Verification
Each mode combination is driven with pulses on all four sources in turn under pass-through. A tick should follow only the selected source, which separates the source mux from the oscillator and pin decode. Every divide tap is run for two full periods after a clear, so an off-by-one tap width or a wrong select encoding shows up as a tick on the wrong pulse. A clear and a mode change are each applied part way through a count and coincide with a source pulse, which shows whether the restart discards the partial count and the coincident edge.

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel #(
  parameter int CNT_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_pulse,
  input  logic       xtal_pulse,
  input  logic       xin_pulse,
  input  logic       alt_pulse,
  input  logic       async_en,
  input  logic       ext_en,
  input  logic       alt_sel,
  input  logic [2:0] div_sel,
  input  logic       pre_clr,
  output logic       tick,
  output logic       osc_en,
  output logic [2:0] pins_free,
  output logic       cfg_err
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [2:0]       mode, mode_q;
  logic [CNT_W-1:0] cnt, cnt_nx, tap_mask;
  logic             src, bad, restart, hit;

  assign mode = {async_en, ext_en, alt_sel};

  always_comb begin
    src = 1'b0; osc_en = 1'b0; pins_free = 3'b000; bad = 1'b0;
    case (mode)
      3'b000, 3'b001: begin src = io_pulse;   pins_free = 3'b111; end
      3'b100:         begin src = xtal_pulse; osc_en = 1'b1; pins_free = 3'b001; end
      3'b110:         begin src = xin_pulse;  pins_free = 3'b011; end
      3'b101:         begin src = alt_pulse;  osc_en = 1'b1; end
      3'b111:         begin src = alt_pulse;  pins_free = 3'b110; end
      default:        bad = 1'b1;
    endcase
  end

  always_comb begin
    case (div_sel)
      3'd2:    tap_mask = (ONE << 3) - ONE;
      3'd3:    tap_mask = (ONE << 5) - ONE;
      3'd4:    tap_mask = (ONE << 6) - ONE;
      3'd5:    tap_mask = (ONE << 7) - ONE;
      3'd6:    tap_mask = (ONE << 8) - ONE;
      default: tap_mask = {CNT_W{1'b1}};
    endcase
  end

  assign restart = pre_clr | (mode != mode_q);
  assign cnt_nx  = cnt + ONE;
  assign hit     = (div_sel == 3'd1) |
                   ((div_sel >= 3'd2) && ((cnt_nx & tap_mask) == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; mode_q <= 3'b000; tick <= 1'b0; cfg_err <= 1'b0;
    end else begin
      mode_q  <= mode;
      cfg_err <= cfg_err | bad;
      tick    <= src & hit & ~restart;
      if (restart)  cnt <= '0;
      else if (src) cnt <= cnt_nx;
    end
  end

  // R6
  undef_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!async_en && ext_en) |=> !tick);
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  // R7
  stop_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel == 3'd0) |=> !tick);
  // R9
  clr_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_clr |=> (!tick && cnt == '0));
  // R10
  mode_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != mode_q) |=> (cnt == '0));
  // R2
  osc_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en |-> (async_en && !ext_en));
  // R8
  tap_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $past(div_sel) >= 3'd2) |-> ((cnt & $past(tap_mask)) == '0));

endmodule

// File: tb/sim_tmr_clk_sel.sv
`timescale 1ns/1ps
module sim_tmr_clk_sel;
  logic clk = 0, rst_n = 0;
  logic io_pulse = 0, xtal_pulse = 0, xin_pulse = 0, alt_pulse = 0;
  logic async_en = 0, ext_en = 0, alt_sel = 0, pre_clr = 0;
  logic [2:0] div_sel = 3'd1;
  logic tick, osc_en, cfg_err;
  logic [2:0] pins_free;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  tmr_clk_sel u0 (.clk, .rst_n, .io_pulse, .xtal_pulse, .xin_pulse, .alt_pulse,
    .async_en, .ext_en, .alt_sel, .div_sel, .pre_clr, .tick, .osc_en,
    .pins_free, .cfg_err);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int which, input bit clr, output logic t);
    io_pulse = (which == 0); xtal_pulse = (which == 1);
    xin_pulse = (which == 2); alt_pulse = (which == 3);
    pre_clr = clr;
    @(negedge clk);
    io_pulse = 0; xtal_pulse = 0; xin_pulse = 0; alt_pulse = 0; pre_clr = 0;
    t = tick;
  endtask

  task automatic set_mode(input bit a, input bit e, input bit s);
    async_en = a; ext_en = e; alt_sel = s;
  endtask

  task automatic do_reset();
    rst_n = 0; idle(3);
    chk("R11 tick in reset", tick, 0);
    rst_n = 1; idle(1);
  endtask

  task automatic t_reset();
    set_mode(0, 0, 0); div_sel = 3'd1;
    do_reset();
    chk("R11 tick", tick, 0);
    chk("R11 cfg_err", cfg_err, 0);
  endtask

  task automatic t_mode(input bit a, input bit e, input bit s, input int osc,
                        input int free, input int good, input string req);
    logic t;
    set_mode(a, e, s); div_sel = 3'd1; idle(2);
    chk({req, " osc_en"}, osc_en, osc);
    chk({req, " pins_free"}, pins_free, free);
    for (int k = 0; k < 4; k++) begin
      pulse(k, 0, t);
      chk($sformatf("%s tick from source %0d", req, k), t, k == good);
    end
  endtask

  task automatic t_undef();
    logic t;
    int got = 0;
    set_mode(0, 1, 0); div_sel = 3'd1; idle(1);
    chk("R6 osc_en", osc_en, 0);
    chk("R6 pins_free", pins_free, 0);
    chk("R6 cfg_err set", cfg_err, 1);
    set_mode(0, 1, 1); idle(1);
    for (int k = 0; k < 4; k++) begin pulse(k, 0, t); got += t; end
    chk("R6 no ticks", got, 0);
    set_mode(0, 0, 0); idle(2);
    chk("R6 cfg_err sticky", cfg_err, 1);
    pulse(0, 0, t);
    chk("R6 ticks resume", t, 1);
    do_reset();
    chk("R6 cfg_err cleared by reset", cfg_err, 0);
  endtask

  task automatic t_stop();
    logic t;
    int got = 0;
    set_mode(0, 0, 0); div_sel = 3'd0; idle(1);
    for (int i = 0; i < 20; i++) begin pulse(0, 0, t); got += t; end
    chk("R7 stop gives no ticks", got, 0);
    div_sel = 3'd1; pulse(0, 0, t);
    chk("R7 pass-through", t, 1);
  endtask

  task automatic t_div();
    logic t;
    set_mode(0, 0, 0);
    for (int sel = 2; sel < 8; sel++) begin
      int n, bad = 0, ticks = 0;
      case (sel)
        2: n = 8; 3: n = 32; 4: n = 64; 5: n = 128; 6: n = 256; default: n = 1024;
      endcase
      div_sel = 3'(sel);
      pre_clr = 1; idle(1); pre_clr = 0;
      for (int i = 1; i <= 2 * n; i++) begin
        pulse(0, 0, t);
        ticks += t;
        if (t != ((i % n) == 0)) bad++;
      end
      chk($sformatf("R8 div %0d misplaced ticks", n), bad, 0);
      chk($sformatf("R8 div %0d tick count", n), ticks, 2);
    end
  endtask

  task automatic t_clr();
    logic t;
    int early = 0;
    set_mode(0, 0, 0); div_sel = 3'd2; pre_clr = 1; idle(1); pre_clr = 0;
    for (int i = 0; i < 5; i++) pulse(0, 0, t);
    pulse(0, 1, t);
    chk("R9 no tick on clear", t, 0);
    for (int i = 0; i < 7; i++) begin pulse(0, 0, t); early += t; end
    chk("R9 no early tick", early, 0);
    pulse(0, 0, t);
    chk("R9 tick on 8th after clear", t, 1);
  endtask

  task automatic t_mode_chg();
    logic t;
    int early = 0;
    set_mode(0, 0, 0); div_sel = 3'd2; pre_clr = 1; idle(1); pre_clr = 0;
    for (int i = 0; i < 5; i++) pulse(0, 0, t);
    set_mode(1, 0, 0);
    pulse(1, 0, t);
    chk("R10 change-cycle pulse not counted", t, 0);
    for (int i = 0; i < 7; i++) begin pulse(1, 0, t); early += t; end
    chk("R10 no early tick", early, 0);
    pulse(1, 0, t);
    chk("R10 tick on 8th after change", t, 1);
  endtask

  initial begin
    idle(1);
    t_reset();
    t_mode(0, 0, 0, 0, 3'b111, 0, "R1");
    t_mode(0, 0, 1, 0, 3'b111, 0, "R1 alt");
    t_mode(1, 0, 0, 1, 3'b001, 1, "R2");
    t_mode(1, 1, 0, 0, 3'b011, 2, "R3");
    t_mode(1, 0, 1, 1, 3'b000, 3, "R4");
    t_mode(1, 1, 1, 0, 3'b110, 3, "R5");
    t_undef();
    t_stop();
    t_div();
    t_clr();
    t_mode_chg();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1ms;
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule